// File: doc/BRIEF.md
# Channel Status Indicator Decoder

This block sits behind the receive front end of a digital audio interface. It gathers the recovered channel-status bit stream one bit per bit-valid strobe, frames it into 192-bit blocks using a block-start strobe, and at the start of the next block decodes the finished block into static indicator outputs. The outputs are one-hot sample-rate flags for 32 kHz, 44.1 kHz and 48 kHz, a copyright flag, a pre-emphasis flag and an indicator that the stream carries professional rather than consumer status.

The decoded values are held between blocks. They only change when a complete block of exactly 192 bits has been gathered. All outputs are gated by the clock-recovery lock input. When lock is lost, the block also drops its partial block and its held values, so it restarts cleanly at the first block start after lock returns. A professional-format block drives none of the consumer flags and raises the professional indicator instead.

Top module: `cs_indicator_decoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all six outputs are 0. No block is held after reset.
- R2: For a consumer block, bits 24 to 27 select the rate. All four 0 gives `rate44_o`. Only bit 25 set gives `rate48_o`. Bits 24 and 25 set with 26 and 27 clear gives `rate32_o`. Any other code leaves all three rate flags 0.
- R3: For a consumer block, `copy_o` is 1 when bit 2 is 0, and 0 when bit 2 is 1.
- R4: For a consumer block, `emph_o` is 1 only when bit 3 is 1 and bits 4 and 5 are both 0.
- R5: Bit 0 is the format bit (0 consumer, 1 professional). A professional block sets `prof_o` to 1 and all five other flags to 0.
- R6: Bit n of a block is the (n+1)-th bit accepted with `bit_vld_i`, counting from the `blk_start_i` cycle. A bit accepted in the `blk_start_i` cycle is bit 0 of the new block. Held values change only in the cycle after a `blk_start_i` that closes a block of exactly 192 bits.
- R7: A block with fewer or more than 192 bits is discarded, and the held values stay unchanged.
- R8: While `lock_i` is 0, all six outputs are 0 in that same cycle.
- R9: A cycle with `lock_i` at 0 clears the held values and the partial block. Bits that arrive after lock returns but before the next `blk_start_i` are ignored.
- R10: Bits that arrive after reset but before the first `blk_start_i` are ignored.
- R11: At most one rate flag is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 1 | Clock-recovery lock, 1 = locked |
| blk_start_i | input | 1 | Strobe marking the first frame of a status block |
| bit_vld_i | input | 1 | Strobe: `cs_bit_i` carries a new status bit |
| cs_bit_i | input | 1 | Recovered channel-status bit |
| rate32_o | output | 1 | 32 kHz sample-rate flag |
| rate44_o | output | 1 | 44.1 kHz sample-rate flag |
| rate48_o | output | 1 | 48 kHz sample-rate flag |
| copy_o | output | 1 | Copyright-protected flag |
| emph_o | output | 1 | Pre-emphasis flag |
| prof_o | output | 1 | Professional-format indicator |

## Verification
A wrong bit count or a wrong armed state shows at the ports at the next block start. Such a fault either latches a block that should have been discarded or misses one that should have been latched, so the flags change one block too early, one block too late, or not at all. A misplaced bit in the gathering register shows as wrong flag values in the cycle after the latching block start, and the per-cycle reference comparison catches it there. Faults in the lock gating show in the same cycle that `lock_i` falls, or in the first cycle after lock returns.

// File: rtl/cs_ind_pkg.sv
package cs_ind_pkg;

    // Bit positions inside a status block that the decoder looks at
    localparam int FMT_POS  = 0;
    localparam int COPY_POS = 2;
    localparam int EMPH_LO  = 3;
    localparam int RATE_LO  = 24;

    // Fields pulled out of a gathered block
    typedef struct packed {
        logic       fmt;
        logic       copy_bit;
        logic [2:0] emph;   // emph[0] is block bit 3
        logic [3:0] rate;   // rate[0] is block bit 24
    } cs_fields_t;

    // Indicator set held between blocks
    typedef struct packed {
        logic r32;
        logic r44;
        logic r48;
        logic copy;
        logic emph;
        logic prof;
    } ind_t;

    localparam ind_t IND_OFF = '0;

    typedef enum logic [1:0] {
        RATE_44,
        RATE_48,
        RATE_32,
        RATE_NONE
    } rate_e;

    function automatic rate_e rate_of(input logic [3:0] code);
        case (code)
            4'b0000: rate_of = RATE_44;
            4'b0010: rate_of = RATE_48;
            4'b0011: rate_of = RATE_32;
            default: rate_of = RATE_NONE;
        endcase
    endfunction

    function automatic ind_t decode(input cs_fields_t f);
        ind_t  r;
        rate_e rt;
        r  = IND_OFF;
        rt = rate_of(f.rate);
        if (f.fmt) begin
            r.prof = 1'b1;
        end else begin
            r.copy = ~f.copy_bit;
            r.emph = (f.emph == 3'b001);
            r.r44  = (rt == RATE_44);
            r.r48  = (rt == RATE_48);
            r.r32  = (rt == RATE_32);
        end
        return r;
    endfunction

endpackage

// File: rtl/cs_bit_collector.sv
module cs_bit_collector
    import cs_ind_pkg::*;
#(
    parameter int BLK_BITS = 192
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lock_i,
    input  logic       blk_start_i,
    input  logic       bit_vld_i,
    input  logic       bit_i,
    output logic       blk_done_o,
    output cs_fields_t fields_o
);
    // Counter saturates one above a full block to mark an overlong block
    localparam int CNT_MAX = BLK_BITS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0]    cnt_q;
    logic                armed_q;
    logic [BLK_BITS-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst || !lock_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (blk_start_i) begin
            armed_q <= 1'b1;
            cnt_q   <= bit_vld_i ? CNT_W'(1) : '0;
        end else if (armed_q && bit_vld_i && (cnt_q < CNT_W'(CNT_MAX))) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Newest bit enters at the top; after a full block bit 0 sits at index 0
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (bit_vld_i) begin
            sr_q <= {bit_i, sr_q[BLK_BITS-1:1]};
        end
    end

    assign blk_done_o = lock_i && armed_q && blk_start_i && (cnt_q == CNT_W'(BLK_BITS));

    assign fields_o.fmt      = sr_q[FMT_POS];
    assign fields_o.copy_bit = sr_q[COPY_POS];
    assign fields_o.emph     = sr_q[EMPH_LO +: 3];
    assign fields_o.rate     = sr_q[RATE_LO +: 4];
endmodule

// File: rtl/cs_field_latch.sv
module cs_field_latch
    import cs_ind_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lock_i,
    input  logic       blk_done_i,
    input  cs_fields_t fields_i,
    output ind_t       held_o
);
    always_ff @(posedge clk) begin
        if (rst || !lock_i) begin
            held_o <= IND_OFF;
        end else if (blk_done_i) begin
            held_o <= decode(fields_i);
        end
    end
endmodule

// File: rtl/cs_output_gate.sv
module cs_output_gate
    import cs_ind_pkg::*;
(
    input  logic lock_i,
    input  ind_t held_i,
    output ind_t ind_o
);
    localparam int IND_W = $bits(ind_t);

    logic [IND_W-1:0] raw;
    logic [IND_W-1:0] gated;

    assign raw = held_i;

    for (genvar g = 0; g < IND_W; g++) begin : g_gate
        assign gated[g] = raw[g] & lock_i;
    end

    assign ind_o = ind_t'(gated);
endmodule

// File: rtl/cs_indicator_decoder.sv
module cs_indicator_decoder
    import cs_ind_pkg::*;
#(
    parameter int BLK_BITS = 192
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_i,
    input  logic blk_start_i,
    input  logic bit_vld_i,
    input  logic cs_bit_i,
    output logic rate32_o,
    output logic rate44_o,
    output logic rate48_o,
    output logic copy_o,
    output logic emph_o,
    output logic prof_o
);
    logic       blk_done;
    cs_fields_t fields;
    ind_t       held;
    ind_t       ind;

    cs_bit_collector #(.BLK_BITS(BLK_BITS)) u_collect (
        .clk         (clk),
        .rst         (rst),
        .lock_i      (lock_i),
        .blk_start_i (blk_start_i),
        .bit_vld_i   (bit_vld_i),
        .bit_i       (cs_bit_i),
        .blk_done_o  (blk_done),
        .fields_o    (fields)
    );

    cs_field_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .lock_i     (lock_i),
        .blk_done_i (blk_done),
        .fields_i   (fields),
        .held_o     (held)
    );

    cs_output_gate u_gate (
        .lock_i (lock_i),
        .held_i (held),
        .ind_o  (ind)
    );

    assign rate32_o = ind.r32;
    assign rate44_o = ind.r44;
    assign rate48_o = ind.r48;
    assign copy_o   = ind.copy;
    assign emph_o   = ind.emph;
    assign prof_o   = ind.prof;
endmodule

// File: rtl/cs_indicator_decoder_chk.sv
module cs_indicator_decoder_chk (
    input logic clk,
    input logic rst,
    input logic lock_i,
    input logic blk_start_i,
    input logic rate32_o,
    input logic rate44_o,
    input logic rate48_o,
    input logic copy_o,
    input logic emph_o,
    input logic prof_o
);
    logic [5:0] outs;
    assign outs = {rate32_o, rate44_o, rate48_o, copy_o, emph_o, prof_o};

    // R1: outputs are clear in the cycle after reset
    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (outs == 6'b0));

    // R11: rate flags never overlap
    assert_rate_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rate32_o, rate44_o, rate48_o}));

    // R5: professional indicator excludes every consumer flag
    assert_prof_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        prof_o |-> ({rate32_o, rate44_o, rate48_o, copy_o, emph_o} == 5'b0));

    // R8: no output while unlocked
    assert_unlock_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !lock_i |-> (outs == 6'b0));

    // R9: a cycle without lock leaves nothing held for the next cycle
    assert_unlock_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !lock_i |=> (outs == 6'b0));

    // R6: outputs only move after a block start while lock stays up
    assert_hold_between_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (lock_i && !blk_start_i) |=> (!lock_i || $stable(outs)));
endmodule

bind cs_indicator_decoder cs_indicator_decoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .lock_i      (lock_i),
    .blk_start_i (blk_start_i),
    .rate32_o    (rate32_o),
    .rate44_o    (rate44_o),
    .rate48_o    (rate48_o),
    .copy_o      (copy_o),
    .emph_o      (emph_o),
    .prof_o      (prof_o)
);

// File: tb/cs_indicator_decoder_bench.sv
`timescale 1ns/100ps
module cs_indicator_decoder_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lock_i = 1'b0;
    logic blk_start_i = 1'b0;
    logic bit_vld_i = 1'b0;
    logic cs_bit_i = 1'b0;
    logic rate32_o, rate44_o, rate48_o, copy_o, emph_o, prof_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    cs_indicator_decoder u_cs_indicator_decoder (
        .clk(clk), .rst(rst), .lock_i(lock_i), .blk_start_i(blk_start_i),
        .bit_vld_i(bit_vld_i), .cs_bit_i(cs_bit_i),
        .rate32_o(rate32_o), .rate44_o(rate44_o), .rate48_o(rate48_o),
        .copy_o(copy_o), .emph_o(emph_o), .prof_o(prof_o)
    );

    // Behavioural reference: a queue of accepted bits and the held flags
    bit m_armed = 0;
    bit m_q[$];
    bit [5:0] m_held = '0;   // {r32,r44,r48,copy,emph,prof}

    function automatic bit [5:0] ref_decode();
        bit [5:0] r = '0;
        bit [3:0] rc;
        if (m_q[0]) return 6'b000001;
        rc = {m_q[27], m_q[26], m_q[25], m_q[24]};
        r[2] = !m_q[2];
        r[1] = m_q[3] && !m_q[4] && !m_q[5];
        if (rc == 4'b0000) r[4] = 1;
        if (rc == 4'b0010) r[3] = 1;
        if (rc == 4'b0011) r[5] = 1;
        return r;
    endfunction

    task automatic ref_clock();
        if (rst) begin
            m_armed = 0; m_q.delete(); m_held = '0;
        end else if (!lock_i) begin
            m_armed = 0; m_q.delete(); m_held = '0;
        end else if (blk_start_i) begin
            if (m_armed && m_q.size() == 192) m_held = ref_decode();
            m_q.delete();
            m_armed = 1;
            if (bit_vld_i) m_q.push_back(cs_bit_i);
        end else if (m_armed && bit_vld_i) begin
            m_q.push_back(cs_bit_i);
        end
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit [5:0] e;
        e = (lock_i && !rst) ? m_held : 6'b0;
        chk(rate32_o, e[5], "R2 rate32");
        chk(rate44_o, e[4], "R2 rate44");
        chk(rate48_o, e[3], "R2 rate48");
        chk(copy_o,   e[2], "R3 copy");
        chk(emph_o,   e[1], "R4 emph");
        chk(prof_o,   e[0], "R5 prof");
    endtask

    task automatic step(input logic lk, input logic bs, input logic bv, input logic b);
        lock_i = lk; blk_start_i = bs; bit_vld_i = bv; cs_bit_i = b;
        @(posedge clk);
        ref_clock();
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [191:0] mk_block(input logic fmt, input logic cpb,
                                              input logic [2:0] em, input logic [3:0] rc);
        logic [191:0] v;
        for (int i = 0; i < 6; i++) v[i*32 +: 32] = $urandom;
        v[0] = fmt; v[2] = cpb; v[5:3] = em; v[27:24] = rc;
        return v;
    endfunction

    task automatic send_block(input logic [191:0] v, input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            step(1, i == 0, 1, v[i % 192]);
            if (gaps && (i % 17 == 5)) step(1, 0, 0, 0);
        end
    endtask

    task automatic close_block();
        step(1, 1, 0, 0);
    endtask

    task automatic expect6(input bit [5:0] e, input string tag);
        chk(rate32_o, e[5], {tag, " rate32"});
        chk(rate44_o, e[4], {tag, " rate44"});
        chk(rate48_o, e[3], {tag, " rate48"});
        chk(copy_o,   e[2], {tag, " copy"});
        chk(emph_o,   e[1], {tag, " emph"});
        chk(prof_o,   e[0], {tag, " prof"});
    endtask

    initial begin : watchdog
        #(5ns * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [191:0] b;
        rst = 1;
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
        expect6(6'b0, "R1 in reset");
        rst = 0;
        step(1, 0, 0, 0);
        expect6(6'b0, "R1 after reset");

        // R10: a full block of bits before any block start is ignored
        b = mk_block(0, 0, 3'b001, 4'b0010);
        for (int i = 0; i < 192; i++) step(1, 0, 1, b[i]);
        close_block();
        expect6(6'b0, "R10 unarmed bits");

        // R2 R3 R4: 48 kHz, protected, emphasis on (bit3=1)
        send_block(mk_block(0, 0, 3'b001, 4'b0010), 192, 0);
        expect6(6'b0, "R6 before close");
        close_block();
        expect6(6'b001110, "R2 48k");

        // 44.1 kHz, copy permitted, emphasis field with bit4 set
        send_block(mk_block(0, 1, 3'b011, 4'b0000), 192, 1);
        close_block();
        expect6(6'b010000, "R4 44k");

        // 32 kHz
        send_block(mk_block(0, 0, 3'b000, 4'b0011), 192, 0);
        close_block();
        expect6(6'b100100, "R2 32k");

        // Unknown rate code
        send_block(mk_block(0, 1, 3'b001, 4'b0001), 192, 1);
        close_block();
        expect6(6'b000010, "R2 unknown code");

        // Professional
        send_block(mk_block(1, 0, 3'b001, 4'b0010), 192, 0);
        close_block();
        expect6(6'b000001, "R5 professional");

        // R7: short and overlong blocks keep the professional state
        send_block(mk_block(0, 0, 3'b001, 4'b0010), 191, 0);
        close_block();
        expect6(6'b000001, "R7 short block");
        send_block(mk_block(0, 0, 3'b001, 4'b0010), 193, 1);
        close_block();
        expect6(6'b000001, "R7 overlong block");

        // R6: back-to-back blocks, each started with a bit in the strobe cycle
        send_block(mk_block(0, 1, 3'b001, 4'b0000), 192, 0);
        send_block(mk_block(0, 0, 3'b000, 4'b0010), 192, 0);
        expect6(6'b010010, "R6 back to back");
        close_block();
        expect6(6'b001100, "R6 second block");

        // R8: lock drops mid block, outputs fall in the same cycle
        b = mk_block(0, 0, 3'b001, 4'b0011);
        for (int i = 0; i < 100; i++) step(1, i == 0, 1, b[i]);
        step(0, 0, 1, b[100]);
        expect6(6'b0, "R8 unlocked");
        // R9: relock, remaining bits without a new start are ignored
        for (int i = 101; i < 192; i++) step(1, 0, 1, b[i]);
        expect6(6'b0, "R9 after relock");
        close_block();
        expect6(6'b0, "R9 partial discarded");
        send_block(b, 192, 1);
        close_block();
        expect6(6'b100110, "R9 fresh block");

        for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule